// File: doc/BRIEF.md
# Five-Stage Pipeline Control and Load Interlock

This block is the control for a classic five-stage integer pipeline (fetch, decode, execute, memory, writeback). It keeps the instruction words that move through the decode/execute, execute/memory and memory/writeback pipeline registers, along with the branch-condition bit captured at the end of execute. From the instruction word in each stage it decodes that stage's own control. The outputs are the two ALU operand selects, the next-PC select, the writeback data select, the destination register number and the register write enable. No central decoder is involved.

The instruction in decode is checked for a read-after-write dependence on a load that sits one stage ahead. When it has one, the block holds the PC and the fetch/decode register and puts a no-op into execute in place of the dependent instruction. Every hazard is resolved before issue, so an instruction that is held back has not yet changed any processor state. A global enable freezes the whole control pipeline while the processor as a whole is stalled.

Instruction fields: opcode in bits [31:26], first source in [25:21], second source or immediate-form destination in [20:16], register-form destination in [15:11].

Top module: `pipe_ctl`

## Requirements
- R1: After reset the three held instruction words are 0 (no-op), the captured branch condition is 0, and `ld_stall`, `sel_pc_target` and `wb_we` are 0 while `pc_we` is 1.
- R2: `sel_a_pc` is 1 exactly when the execute-stage word has opcode 6'b000100 (branch-if-zero), and 0 otherwise.
- R3: `sel_b_reg` is 1 exactly when the execute-stage word has opcode 6'b000000 (register-register ALU), and 0 otherwise. Every other type takes the immediate.
- R4: `sel_pc_target` is 1 in the cycle after a branch-if-zero word leaves execute, provided `ex_zero` was 1 at the clock edge that moved it on. In all other cases it is 0.
- R5: `sel_wb_mem` is 1 exactly when the writeback-stage word has opcode 6'b100011 (load).
- R6: `wb_dest` is bits [15:11] of the writeback-stage word when its opcode is 6'b000000, and bits [20:16] otherwise.
- R7: `wb_we` is 1 exactly when the writeback-stage opcode is 6'b000000, 6'b001xxx (ALU-immediate) or 6'b100011, and `wb_dest` is non-zero. Store (6'b101011), branch and all other opcodes never write.
- R8: `ld_stall` is 1 exactly when the execute-stage word is a load with a non-zero bits [20:16] destination that the decode word reads. Register-register and store words read [25:21] and [20:16]. ALU-immediate, load and branch words read only [25:21]. While `ld_stall` is 1, `pc_we` and `ifid_we` are 0.
- R9: A stall with `pipe_en` high loads 0 into the execute-stage word. The held decode word issues on the next edge once the stall is gone.
- R10: With `pipe_en` high and no stall, each edge moves `id_instr` into execute, execute into memory, and memory into writeback.
- R11: With `pipe_en` low, all held words and the branch condition keep their values, and `pc_we` and `ifid_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_en | input | 1 | Global pipeline advance enable |
| id_instr | input | 32 | Instruction word currently in decode |
| ex_zero | input | 1 | Execute-stage operand-equals-zero flag |
| ld_stall | output | 1 | Load interlock detected |
| pc_we | output | 1 | PC register write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| sel_pc_target | output | 1 | Next-PC select: 1 = branch target, 0 = incremented PC |
| sel_a_pc | output | 1 | ALU operand A select: 1 = PC, 0 = register |
| sel_b_reg | output | 1 | ALU operand B select: 1 = register, 0 = immediate |
| sel_wb_mem | output | 1 | Writeback data select: 1 = load data, 0 = ALU result |
| wb_dest | output | 5 | Writeback destination register number |
| wb_we | output | 1 | Register file write enable |
| idex_ir | output | 32 | Execute-stage instruction word |
| exmem_ir | output | 32 | Memory-stage instruction word |
| memwb_ir | output | 32 | Writeback-stage instruction word |

## Verification
The checker assumes that `pipe_en`, `id_instr` and `ex_zero` hold known values at each sampled edge. It also assumes that the decode word stays constant while a stall is held, which is what the fetch/decode register does once its write enable is low. The bench changes inputs one time unit after the rising edge and keeps `id_instr` fixed during each interlock case. Its sweeps cover every defined opcode class and an unused opcode, zero and non-zero destination fields, and both branch-condition values.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

  localparam int IW   = 32;
  localparam int OP_W = 6;
  localparam int RA_W = 5;

  localparam int OP_LSB = IW - OP_W;
  localparam int RS_LSB = OP_LSB - RA_W;
  localparam int RT_LSB = RS_LSB - RA_W;
  localparam int RD_LSB = RT_LSB - RA_W;

  localparam logic [OP_W-1:0] OPC_RR     = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQZ   = 6'b000100;
  localparam logic [2:0]      OPC_IMM_HI = 3'b001;

  localparam logic [IW-1:0] NOP_WORD = '0;

  typedef enum logic [2:0] {
    CLS_OTHER,
    CLS_RR,
    CLS_IMM,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH
  } icls_e;

  typedef struct packed {
    icls_e           cls;
    logic            writes_reg;
    logic            reads_rs;
    logic            reads_rt;
    logic [RA_W-1:0] rs;
    logic [RA_W-1:0] rt;
    logic [RA_W-1:0] dest;
  } idec_t;

endpackage

// File: rtl/pipe_ctl_decode.sv
module pipe_ctl_decode
  import pipe_ctl_pkg::*;
(
  input  logic [IW-1:0] instr,
  output idec_t         dec
);

  logic [OP_W-1:0] opc;
  icls_e           cls;

  assign opc = instr[OP_LSB +: OP_W];

  always_comb begin
    if (opc == OPC_RR) begin
      cls = CLS_RR;
    end else if (opc == OPC_LOAD) begin
      cls = CLS_LOAD;
    end else if (opc == OPC_STORE) begin
      cls = CLS_STORE;
    end else if (opc == OPC_BEQZ) begin
      cls = CLS_BRANCH;
    end else if (opc[OP_W-1 -: 3] == OPC_IMM_HI) begin
      cls = CLS_IMM;
    end else begin
      cls = CLS_OTHER;
    end
  end

  always_comb begin
    dec.cls        = cls;
    dec.rs         = instr[RS_LSB +: RA_W];
    dec.rt         = instr[RT_LSB +: RA_W];
    dec.writes_reg = 1'b0;
    dec.reads_rs   = 1'b0;
    dec.reads_rt   = 1'b0;
    dec.dest       = instr[RT_LSB +: RA_W];
    unique case (cls)
      CLS_RR: begin
        dec.writes_reg = 1'b1;
        dec.reads_rs   = 1'b1;
        dec.reads_rt   = 1'b1;
        dec.dest       = instr[RD_LSB +: RA_W];
      end
      CLS_IMM: begin
        dec.writes_reg = 1'b1;
        dec.reads_rs   = 1'b1;
      end
      CLS_LOAD: begin
        dec.writes_reg = 1'b1;
        dec.reads_rs   = 1'b1;
      end
      CLS_STORE: begin
        dec.reads_rs   = 1'b1;
        dec.reads_rt   = 1'b1;
      end
      CLS_BRANCH: begin
        dec.reads_rs   = 1'b1;
      end
      default: begin
        dec.writes_reg = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pipe_ctl_interlock.sv
module pipe_ctl_interlock
  import pipe_ctl_pkg::*;
(
  input  idec_t id_dec,
  input  idec_t ex_dec,
  output logic  stall
);

  logic            ex_is_src;
  logic [RA_W-1:0] ld_reg;
  logic            hit_rs;
  logic            hit_rt;

  always_comb begin
    ld_reg    = ex_dec.dest;
    ex_is_src = (ex_dec.cls == CLS_LOAD) && (ld_reg != '0);
    hit_rs    = id_dec.reads_rs && (id_dec.rs == ld_reg);
    hit_rt    = id_dec.reads_rt && (id_dec.rt == ld_reg);
    stall     = ex_is_src && (hit_rs || hit_rt);
  end

endmodule

// File: rtl/pipe_ctl_stage_regs.sv
module pipe_ctl_stage_regs
  import pipe_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          bubble,
  input  logic [IW-1:0] id_word,
  input  logic          cond_in,
  output logic [IW-1:0] ex_word,
  output logic [IW-1:0] mem_word,
  output logic [IW-1:0] wb_word,
  output logic          cond_q
);

  logic [IW-1:0] ex_word_nx;
  logic [IW-1:0] mem_word_nx;
  logic [IW-1:0] wb_word_nx;
  logic          cond_nx;

  always_comb begin
    ex_word_nx  = ex_word;
    mem_word_nx = mem_word;
    wb_word_nx  = wb_word;
    cond_nx     = cond_q;
    if (adv_en) begin
      ex_word_nx  = bubble ? NOP_WORD : id_word;
      mem_word_nx = ex_word;
      wb_word_nx  = mem_word;
      cond_nx     = cond_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_word  <= NOP_WORD;
      mem_word <= NOP_WORD;
      wb_word  <= NOP_WORD;
      cond_q   <= 1'b0;
    end else begin
      ex_word  <= ex_word_nx;
      mem_word <= mem_word_nx;
      wb_word  <= wb_word_nx;
      cond_q   <= cond_nx;
    end
  end

endmodule

// File: rtl/pipe_ctl_selects.sv
module pipe_ctl_selects
  import pipe_ctl_pkg::*;
(
  input  idec_t           ex_dec,
  input  idec_t           wb_dec,
  input  logic            cond_q,
  output logic            sel_pc_target,
  output logic            sel_a_pc,
  output logic            sel_b_reg,
  output logic            sel_wb_mem,
  output logic [RA_W-1:0] wb_dest,
  output logic            wb_we
);

  always_comb begin
    sel_a_pc  = (ex_dec.cls == CLS_BRANCH);
    sel_b_reg = (ex_dec.cls == CLS_RR);
  end

  always_comb begin
    sel_pc_target = cond_q;
  end

  always_comb begin
    sel_wb_mem = (wb_dec.cls == CLS_LOAD);
    wb_dest    = wb_dec.dest;
    wb_we      = wb_dec.writes_reg && (wb_dec.dest != '0);
  end

endmodule

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pipe_en,
  input  logic [IW-1:0]   id_instr,
  input  logic            ex_zero,
  output logic            ld_stall,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            sel_pc_target,
  output logic            sel_a_pc,
  output logic            sel_b_reg,
  output logic            sel_wb_mem,
  output logic [RA_W-1:0] wb_dest,
  output logic            wb_we,
  output logic [IW-1:0]   idex_ir,
  output logic [IW-1:0]   exmem_ir,
  output logic [IW-1:0]   memwb_ir
);

  localparam int NSTG     = 4;
  localparam int STG_ID   = 0;
  localparam int STG_EX   = 1;
  localparam int STG_MEM  = 2;
  localparam int STG_WB   = 3;
  localparam int SYNC_LEN = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
    end
  end

  assign rst_n_s = rst_pipe[SYNC_LEN-1];

  logic [IW-1:0] stage_word [NSTG];
  idec_t         stage_dec  [NSTG];
  logic          cond_q;
  logic          cond_in;
  logic          bubble;

  assign stage_word[STG_ID]  = id_instr;
  assign stage_word[STG_EX]  = idex_ir;
  assign stage_word[STG_MEM] = exmem_ir;
  assign stage_word[STG_WB]  = memwb_ir;

  for (genvar g = 0; g < NSTG; g++) begin : g_dec
    pipe_ctl_decode u_dec (
      .instr (stage_word[g]),
      .dec   (stage_dec[g])
    );
  end

  pipe_ctl_interlock u_lock (
    .id_dec (stage_dec[STG_ID]),
    .ex_dec (stage_dec[STG_EX]),
    .stall  (ld_stall)
  );

  always_comb begin
    bubble  = ld_stall;
    pc_we   = pipe_en && !ld_stall;
    ifid_we = pipe_en && !ld_stall;
    cond_in = (stage_dec[STG_EX].cls == CLS_BRANCH) && ex_zero;
  end

  pipe_ctl_stage_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .adv_en   (pipe_en),
    .bubble   (bubble),
    .id_word  (id_instr),
    .cond_in  (cond_in),
    .ex_word  (idex_ir),
    .mem_word (exmem_ir),
    .wb_word  (memwb_ir),
    .cond_q   (cond_q)
  );

  pipe_ctl_selects u_sel (
    .ex_dec        (stage_dec[STG_EX]),
    .wb_dec        (stage_dec[STG_WB]),
    .cond_q        (cond_q),
    .sel_pc_target (sel_pc_target),
    .sel_a_pc      (sel_a_pc),
    .sel_b_reg     (sel_b_reg),
    .sel_wb_mem    (sel_wb_mem),
    .wb_dest       (wb_dest),
    .wb_we         (wb_we)
  );

endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk
  import pipe_ctl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pipe_en,
  input logic            ld_stall,
  input logic            pc_we,
  input logic            ifid_we,
  input logic            sel_pc_target,
  input logic            sel_a_pc,
  input logic            sel_b_reg,
  input logic            sel_wb_mem,
  input logic [RA_W-1:0] wb_dest,
  input logic            wb_we,
  input logic [IW-1:0]   idex_ir,
  input logic [IW-1:0]   exmem_ir,
  input logic [IW-1:0]   memwb_ir
);

  AST_STALL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> (!pc_we && !ifid_we)); // R8

  AST_BUBBLE_ENTERS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stall && pipe_en) |=> (idex_ir == NOP_WORD)); // R9

  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_dest != '0)); // R7

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_en |=> ($stable(idex_ir) && $stable(exmem_ir) && $stable(memwb_ir)
                  && $stable(sel_pc_target))); // R11

  AST_SHIFT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_en |=> (exmem_ir == $past(idex_ir))); // R10

  AST_SHIFT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_en |=> (memwb_ir == $past(exmem_ir))); // R10

  AST_TARGET_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pc_target |-> (exmem_ir[OP_LSB +: OP_W] == OPC_BEQZ)); // R4

  AST_OPERAND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a_pc |-> !sel_b_reg); // R2

  AST_LOAD_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wb_mem |-> (wb_dest == memwb_ir[RT_LSB +: RA_W])); // R6

endmodule

bind pipe_ctl pipe_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pipe_en       (pipe_en),
  .ld_stall      (ld_stall),
  .pc_we         (pc_we),
  .ifid_we       (ifid_we),
  .sel_pc_target (sel_pc_target),
  .sel_a_pc      (sel_a_pc),
  .sel_b_reg     (sel_b_reg),
  .sel_wb_mem    (sel_wb_mem),
  .wb_dest       (wb_dest),
  .wb_we         (wb_we),
  .idex_ir       (idex_ir),
  .exmem_ir      (exmem_ir),
  .memwb_ir      (memwb_ir)
);

// File: tb/sim_pipe_ctl.sv
module sim_pipe_ctl;

  localparam int CLK_PER = 10;
  localparam int WDOG    = 100000;

  logic        clk;
  logic        rst_n;
  logic        pipe_en;
  logic [31:0] id_instr;
  logic        ex_zero;
  logic        ld_stall, pc_we, ifid_we, sel_pc_target, sel_a_pc, sel_b_reg;
  logic        sel_wb_mem, wb_we;
  logic [4:0]  wb_dest;
  logic [31:0] idex_ir, exmem_ir, memwb_ir;

  int n_chk;
  int n_bad;
  int cyc;
  bit done;

  pipe_ctl u0 (
    .clk (clk), .rst_n (rst_n), .pipe_en (pipe_en), .id_instr (id_instr),
    .ex_zero (ex_zero), .ld_stall (ld_stall), .pc_we (pc_we), .ifid_we (ifid_we),
    .sel_pc_target (sel_pc_target), .sel_a_pc (sel_a_pc), .sel_b_reg (sel_b_reg),
    .sel_wb_mem (sel_wb_mem), .wb_dest (wb_dest), .wb_we (wb_we),
    .idex_ir (idex_ir), .exmem_ir (exmem_ir), .memwb_ir (memwb_ir)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER/2) clk = ~clk;
  end

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd);
    return {op, rs, rt, rd, 11'h2a5};
  endfunction

  function automatic logic [5:0] opsel(input int i);
    case (i)
      0: return 6'b000000;
      1: return 6'b001000;
      2: return 6'b001101;
      3: return 6'b100011;
      4: return 6'b101011;
      5: return 6'b000100;
      6: return 6'b111111;
      default: return 6'b000010;
    endcase
  endfunction

  function automatic logic exp_writer(input logic [5:0] op);
    return (op == 6'b000000) || (op[5:3] == 3'b001) || (op == 6'b100011);
  endfunction

  function automatic logic [4:0] exp_dest(input logic [31:0] w);
    return (w[31:26] == 6'b000000) ? w[15:11] : w[20:16];
  endfunction

  function automatic logic exp_stall(input logic [31:0] idw, input logic [4:0] ld);
    logic [5:0] op;
    logic rd_rs, rd_rt;
    op    = idw[31:26];
    rd_rs = exp_writer(op) || (op == 6'b101011) || (op == 6'b000100);
    rd_rt = (op == 6'b000000) || (op == 6'b101011);
    return (ld != 5'd0) && ((rd_rs && idw[25:21] == ld) || (rd_rt && idw[20:16] == ld));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic flush();
    id_instr = '0;
    ex_zero  = 1'b0;
    pipe_en  = 1'b1;
    for (int k = 0; k < 3; k++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
        finish_run();
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; pipe_en = 1'b1; id_instr = '0; ex_zero = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 idex", idex_ir, 0);
    chk("R1 exmem", exmem_ir, 0);
    chk("R1 memwb", memwb_ir, 0);
    chk("R1 stall", {31'b0, ld_stall}, 0);
    chk("R1 target", {31'b0, sel_pc_target}, 0);
    chk("R1 wb_we", {31'b0, wb_we}, 0);
    chk("R1 pc_we", {31'b0, pc_we}, 1);

    // opcode / field / condition sweep through all stages
    for (int oi = 0; oi < 8; oi++) begin
      for (int ti = 0; ti < 2; ti++) begin
        for (int di = 0; di < 2; di++) begin
          for (int z = 0; z < 2; z++) begin
            logic [5:0]  op;
            logic [31:0] w;
            op = opsel(oi);
            w  = mk(op, 5'd5, ti ? 5'd7 : 5'd0, di ? 5'd12 : 5'd0);
            id_instr = w;
            ex_zero  = z[0];
            tick();
            id_instr = '0;
            chk("R10 enter ex", idex_ir, w);
            chk("R2 sel_a_pc", {31'b0, sel_a_pc}, {31'b0, op == 6'b000100});
            chk("R3 sel_b_reg", {31'b0, sel_b_reg}, {31'b0, op == 6'b000000});
            tick();
            ex_zero = 1'b0;
            chk("R10 enter mem", exmem_ir, w);
            chk("R4 sel_pc_target", {31'b0, sel_pc_target},
                {31'b0, (op == 6'b000100) && z[0]});
            tick();
            chk("R10 enter wb", memwb_ir, w);
            chk("R4 target clears", {31'b0, sel_pc_target}, 0);
            chk("R5 sel_wb_mem", {31'b0, sel_wb_mem}, {31'b0, op == 6'b100011});
            chk("R6 wb_dest", {27'b0, wb_dest}, {27'b0, exp_dest(w)});
            chk("R7 wb_we", {31'b0, wb_we},
                {31'b0, exp_writer(op) && (exp_dest(w) != 5'd0)});
          end
        end
      end
    end

    // load interlock sweep
    for (int oi = 0; oi < 8; oi++) begin
      for (int dd = 0; dd < 2; dd++) begin
        for (int p = 0; p < 3; p++) begin
          logic [4:0]  d;
          logic [31:0] w;
          logic        es;
          flush();
          d = dd ? 5'd9 : 5'd0;
          w = mk(opsel(oi), (p == 0) ? d : 5'd1, (p == 1) ? d : 5'd2, 5'd3);
          es = exp_stall(w, d);
          id_instr = mk(6'b100011, 5'd3, d, 5'd0);
          tick();
          id_instr = w;
          #1;
          chk("R8 ld_stall", {31'b0, ld_stall}, {31'b0, es});
          chk("R8 pc_we", {31'b0, pc_we}, {31'b0, !es});
          chk("R8 ifid_we", {31'b0, ifid_we}, {31'b0, !es});
          tick();
          if (es) begin
            chk("R9 bubble", idex_ir, 0);
            chk("R9 stall gone", {31'b0, ld_stall}, 0);
            tick();
            chk("R9 reissue", idex_ir, w);
          end else begin
            chk("R10 issue", idex_ir, w);
          end
        end
      end
    end

    // freeze
    flush();
    begin
      logic [31:0] a, b;
      a = mk(6'b001000, 5'd1, 5'd4, 5'd0);
      b = mk(6'b000000, 5'd2, 5'd3, 5'd6);
      id_instr = a; tick();
      id_instr = b; tick();
      pipe_en = 1'b0;
      id_instr = mk(6'b100011, 5'd1, 5'd8, 5'd0);
      #1;
      chk("R11 pc_we low", {31'b0, pc_we}, 0);
      chk("R11 ifid_we low", {31'b0, ifid_we}, 0);
      tick(); tick();
      chk("R11 idex hold", idex_ir, b);
      chk("R11 exmem hold", exmem_ir, a);
      chk("R11 memwb hold", memwb_ir, 0);
      pipe_en = 1'b1;
      id_instr = mk(6'b100011, 5'd1, 5'd8, 5'd0);
      tick();
      id_instr = mk(6'b101011, 5'd4, 5'd8, 5'd0);
      pipe_en = 1'b0;
      #1;
      chk("R8 stall under freeze", {31'b0, ld_stall}, 1);
      tick();
      chk("R11 no bubble while frozen", idex_ir, mk(6'b100011, 5'd1, 5'd8, 5'd0));
      pipe_en = 1'b1;
      tick();
      chk("R9 bubble after unfreeze", idex_ir, 0);
    end

    finish_run();
  end

endmodule